// File: doc/BRIEF.md
# Multi-Channel Serial Interrupt Aggregator

This block gathers interrupt causes from up to four port groups of eight serial channels each and merges them onto one host interrupt line. Every channel keeps a sticky byte of cause flags, fed by event pulses from its receive and transmit logic and by edges on its three synchronised modem-status inputs. A per-channel enable byte decides which of these flags turn into a channel interrupt. Each group reports its interrupting channels in one byte, and a controller status byte shows which groups have at least one interrupting channel.

The host line has an enable bit and is latched. It stays high until software writes an end-of-interrupt strobe, and it comes back on the following cycle if any enabled cause is still pending. Software reaches all state through a byte-wide register port with a one-cycle read latency. A per-group command register can hold every channel of that group in reset.

Address layout (8-bit address): when bit 7 is 0, bits 6:5 select the group. Within a group, offset 0x00+c is the cause byte of channel c, 0x08+c is its enable byte, 0x10 is the interrupting-channel byte and 0x11 is the command register. 0x80 is the controller status byte and 0x81 is the controller control byte.

Top module: `serial_irq_aggregator`

## Requirements
- R1: A pulse on a channel's receive-trigger, transmit-empty or special-receive event input sets bit 5, bit 4 or bit 3 of that channel's cause byte. The bit stays set until the cause byte is read. The read returns the flags held before the read and then clears them, except for a flag whose event arrives in the same cycle.
- R2: Any edge, rising or falling, on a channel's CD, CTS or DSR input sets bit 2, bit 1 or bit 0 of its cause byte once the input has passed the synchroniser. A read of the cause byte clears these bits.
- R3: The enable byte holds bit 0 (modem causes, bits 2..0), bit 1 (receive trigger), bit 2 (special receive) and bit 3 (transmit empty); it reads back with bits 7..4 zero. A channel interrupts exactly when a set cause flag has its enable bit set.
- R4: The receive-trigger flag (cause bit 5) is set even while enable bit 1 is clear. Only the channel interrupt is gated by that enable.
- R5: The interrupting-channel byte of a group reports channel c in bit c, and a set bit means that channel is interrupting. Reading it clears nothing.
- R6: Controller status bit g is set when group g has any interrupting channel. Bits 7..4, and the bits of groups that do not exist, always read as zero.
- R7: Control bit 3 is the host enable and reads back at bit 3. host_irq rises only while the host enable is set. It rises one cycle after an interrupting channel is present with the enable set.
- R8: host_irq stays high even after the causes are cleared, until a control write with bit 2 set (end-of-interrupt). That write clears host_irq at its clock edge, and host_irq rises again on the next edge if an enabled cause is still pending.
- R9: Writing 0x80 to a group's command register holds every channel of that group with cause and enable bytes cleared and events ignored. Writing 0x00 releases the group. Other groups are unaffected.
- R10: reg_rdata shows the addressed register one cycle after reg_rd and is zero in every other cycle. Unmapped addresses and the write-only command register read as zero.
- R11: After synchronous reset, host_irq, reg_rdata and all cause, enable, status and control state are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_rx_trig | input | NUM_GROUPS*CHANS | Receive FIFO trigger-level event pulses, index g*CHANS+c |
| evt_tx_empty | input | NUM_GROUPS*CHANS | Transmit FIFO empty event pulses |
| evt_special | input | NUM_GROUPS*CHANS | Special receive condition event pulses |
| cd_in | input | NUM_GROUPS*CHANS | Asynchronous carrier-detect levels |
| cts_in | input | NUM_GROUPS*CHANS | Asynchronous clear-to-send levels |
| dsr_in | input | NUM_GROUPS*CHANS | Asynchronous data-set-ready levels |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| host_irq | output | 1 | Latched host interrupt |

## Verification
A channel flag stuck or lost shows up one cycle later in the group byte and the controller status. It also shows up in host_irq, which rises one edge after the flag when the host enable is set. A wrong clear-on-read is seen at the second read of the same cause byte. A latch that ignores the end-of-interrupt strobe, or that fails to re-arm, shows at host_irq within two cycles of the strobe. A group reset that leaks into other groups shows when a neighbour's cause byte is read after the reset is released.

// File: rtl/sia_pkg.sv
package sia_pkg;
  // cause byte bit positions
  localparam int CAUSE_RXTRIG  = 5;
  localparam int CAUSE_TXMT    = 4;
  localparam int CAUSE_SPECIAL = 3;
  localparam int CAUSE_CD      = 2;
  localparam int CAUSE_CTS     = 1;
  localparam int CAUSE_DSR     = 0;
  localparam int CAUSE_W       = 6;

  // enable byte bit positions
  localparam int EN_MODEM   = 0;
  localparam int EN_RX      = 1;
  localparam int EN_SPECIAL = 2;
  localparam int EN_TX      = 3;
  localparam int EN_W       = 4;

  // controller control byte
  localparam int HOST_EN_BIT = 3;
  localparam int EOI_BIT     = 2;
  localparam int GRP_RST_BIT = 7;

  // address layout
  localparam int CHAN_IDX_W = 3;
  localparam int GRP_IDX_W  = 2;
  localparam logic [7:0] ADDR_STATUS  = 8'h80;
  localparam logic [7:0] ADDR_CONTROL = 8'h81;
  localparam logic [3:0] GOFF_INTCHAN = 4'h0;
  localparam logic [3:0] GOFF_CMD     = 4'h1;
endpackage

// File: rtl/sia_modem_sync.sv
module sia_modem_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int LINES       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] lvl_in,
  output logic [LINES-1:0] edge_out
);
  logic [LINES-1:0] sync_q [SYNC_STAGES];
  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= lvl_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign edge_out = sync_q[SYNC_STAGES-1] ^ prev_q;
endmodule

// File: rtl/sia_channel.sv
module sia_channel
  import sia_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       grp_rst,
  input  logic       ev_rx_trig,
  input  logic       ev_tx_empty,
  input  logic       ev_special,
  input  logic [2:0] modem_edge,   // {cd, cts, dsr}
  input  logic       en_wr,
  input  logic [7:0] wdata,
  input  logic       cause_rd,
  output logic [7:0] cause,
  output logic [7:0] enable,
  output logic       irq
);
  logic [CAUSE_W-1:0] cause_q;
  logic [EN_W-1:0]    en_q;
  logic [CAUSE_W-1:0] set_v;

  assign set_v = {ev_rx_trig, ev_tx_empty, ev_special, modem_edge};

  always_ff @(posedge clk) begin
    if (rst || grp_rst) begin
      cause_q <= '0;
      en_q    <= '0;
    end else begin
      if (en_wr) en_q <= wdata[EN_W-1:0];
      cause_q <= (cause_rd ? '0 : cause_q) | set_v;
    end
  end

  always_comb begin
    irq = (cause_q[CAUSE_RXTRIG]  && en_q[EN_RX])      ||
          (cause_q[CAUSE_TXMT]    && en_q[EN_TX])      ||
          (cause_q[CAUSE_SPECIAL] && en_q[EN_SPECIAL]) ||
          ((|cause_q[CAUSE_CD:CAUSE_DSR]) && en_q[EN_MODEM]);
  end

  assign cause  = {{(8-CAUSE_W){1'b0}}, cause_q};
  assign enable = {{(8-EN_W){1'b0}}, en_q};
endmodule

// File: rtl/sia_group.sv
module sia_group
  import sia_pkg::*;
#(
  parameter int CHANS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CHANS-1:0]      evt_rx_trig,
  input  logic [CHANS-1:0]      evt_tx_empty,
  input  logic [CHANS-1:0]      evt_special,
  input  logic [CHANS-1:0]      cd_in,
  input  logic [CHANS-1:0]      cts_in,
  input  logic [CHANS-1:0]      dsr_in,
  input  logic [CHAN_IDX_W-1:0] chan_sel,
  input  logic                  en_wr,
  input  logic                  cause_rd,
  input  logic                  cmd_wr,
  input  logic [7:0]            wdata,
  output logic [7:0]            sel_cause,
  output logic [7:0]            sel_enable,
  output logic [7:0]            int_chan,
  output logic                  grp_flag
);
  logic             grp_rst_q;
  logic [CHANS-1:0] irq_vec;
  logic [7:0]       cause_a  [CHANS];
  logic [7:0]       enable_a [CHANS];

  always_ff @(posedge clk) begin
    if (rst)         grp_rst_q <= 1'b0;
    else if (cmd_wr) grp_rst_q <= wdata[GRP_RST_BIT];
  end

  for (genvar c = 0; c < CHANS; c++) begin : g_chan
    logic [2:0] medge;
    logic       hit;
    assign hit = (chan_sel == CHAN_IDX_W'(c));

    sia_modem_sync #(.SYNC_STAGES(SYNC_STAGES), .LINES(3)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .lvl_in   ({cd_in[c], cts_in[c], dsr_in[c]}),
      .edge_out (medge)
    );

    sia_channel u_chan (
      .clk         (clk),
      .rst         (rst),
      .grp_rst     (grp_rst_q),
      .ev_rx_trig  (evt_rx_trig[c]),
      .ev_tx_empty (evt_tx_empty[c]),
      .ev_special  (evt_special[c]),
      .modem_edge  (medge),
      .en_wr       (en_wr && hit),
      .wdata       (wdata),
      .cause_rd    (cause_rd && hit),
      .cause       (cause_a[c]),
      .enable      (enable_a[c]),
      .irq         (irq_vec[c])
    );
  end

  always_comb begin
    sel_cause  = '0;
    sel_enable = '0;
    for (int c = 0; c < CHANS; c++) begin
      if (chan_sel == CHAN_IDX_W'(c)) begin
        sel_cause  = cause_a[c];
        sel_enable = enable_a[c];
      end
    end
  end

  assign int_chan = 8'(irq_vec);
  assign grp_flag = |irq_vec;
endmodule

// File: rtl/serial_irq_aggregator.sv
module serial_irq_aggregator
  import sia_pkg::*;
#(
  parameter int NUM_GROUPS  = 4,
  parameter int CHANS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_GROUPS*CHANS-1:0] evt_rx_trig,
  input  logic [NUM_GROUPS*CHANS-1:0] evt_tx_empty,
  input  logic [NUM_GROUPS*CHANS-1:0] evt_special,
  input  logic [NUM_GROUPS*CHANS-1:0] cd_in,
  input  logic [NUM_GROUPS*CHANS-1:0] cts_in,
  input  logic [NUM_GROUPS*CHANS-1:0] dsr_in,
  input  logic                        reg_wr,
  input  logic                        reg_rd,
  input  logic [7:0]                  reg_addr,
  input  logic [7:0]                  reg_wdata,
  output logic [7:0]                  reg_rdata,
  output logic                        host_irq
);
  localparam int GMSB = 5 + GRP_IDX_W - 1;

  logic [NUM_GROUPS-1:0] grp_flags;
  logic [7:0]            g_cause [NUM_GROUPS];
  logic [7:0]            g_en    [NUM_GROUPS];
  logic [7:0]            g_ichan [NUM_GROUPS];
  logic                  host_en_q;
  logic                  irq_q;
  logic [7:0]            rdata_q;
  logic                  eoi;
  logic                  any_grp;
  logic                  is_grp_space;
  logic [GRP_IDX_W-1:0]  grp_idx;

  assign is_grp_space = !reg_addr[7];
  assign grp_idx      = reg_addr[GMSB:5];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic sel;
    assign sel = is_grp_space && (grp_idx == GRP_IDX_W'(g));

    sia_group #(.CHANS(CHANS), .SYNC_STAGES(SYNC_STAGES)) u_grp (
      .clk          (clk),
      .rst          (rst),
      .evt_rx_trig  (evt_rx_trig [g*CHANS +: CHANS]),
      .evt_tx_empty (evt_tx_empty[g*CHANS +: CHANS]),
      .evt_special  (evt_special [g*CHANS +: CHANS]),
      .cd_in        (cd_in [g*CHANS +: CHANS]),
      .cts_in       (cts_in[g*CHANS +: CHANS]),
      .dsr_in       (dsr_in[g*CHANS +: CHANS]),
      .chan_sel     (reg_addr[CHAN_IDX_W-1:0]),
      .en_wr        (reg_wr && sel && !reg_addr[4] &&  reg_addr[3]),
      .cause_rd     (reg_rd && sel && !reg_addr[4] && !reg_addr[3]),
      .cmd_wr       (reg_wr && sel && reg_addr[4] && (reg_addr[3:0] == GOFF_CMD)),
      .wdata        (reg_wdata),
      .sel_cause    (g_cause[g]),
      .sel_enable   (g_en[g]),
      .int_chan     (g_ichan[g]),
      .grp_flag     (grp_flags[g])
    );
  end

  assign any_grp = |grp_flags;
  assign eoi     = reg_wr && (reg_addr == ADDR_CONTROL) && reg_wdata[EOI_BIT];

  // host enable and latched interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      host_en_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == ADDR_CONTROL) host_en_q <= reg_wdata[HOST_EN_BIT];
      if (eoi) irq_q <= 1'b0;
      else     irq_q <= irq_q || (host_en_q && any_grp);
    end
  end

  // read mux
  logic [7:0] grp_rd_val;
  always_comb begin
    grp_rd_val = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (grp_idx == GRP_IDX_W'(g)) begin
        if (!reg_addr[4])
          grp_rd_val = reg_addr[3] ? g_en[g] : g_cause[g];
        else if (reg_addr[3:0] == GOFF_INTCHAN)
          grp_rd_val = g_ichan[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !reg_rd) begin
      rdata_q <= '0;
    end else if (is_grp_space) begin
      rdata_q <= grp_rd_val;
    end else if (reg_addr == ADDR_STATUS) begin
      rdata_q <= 8'(grp_flags) & 8'h0F;
    end else if (reg_addr == ADDR_CONTROL) begin
      rdata_q <= 8'(host_en_q) << HOST_EN_BIT;
    end else begin
      rdata_q <= '0;
    end
  end

  assign reg_rdata = rdata_q;
  assign host_irq  = irq_q;
endmodule

// File: rtl/serial_irq_aggregator_chk.sv
module serial_irq_aggregator_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       host_irq,
  input logic       host_en,
  input logic       any_pending
);
  logic eoi_w;
  assign eoi_w = reg_wr && (reg_addr == 8'h81) && reg_wdata[2];

  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (rst)
    eoi_w |=> !host_irq);                                             // R8

  AST_PENDING_RAISES: assert property (@(posedge clk) disable iff (rst)
    (host_en && any_pending && !eoi_w) |=> host_irq);                 // R7

  AST_RISE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(host_irq) |-> $past(host_en));                              // R7

  AST_STATUS_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 8'h80) |=> (reg_rdata[7:4] == 4'h0));      // R6

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == 8'h00));                                // R10
endmodule

bind serial_irq_aggregator serial_irq_aggregator_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .host_irq    (host_irq),
  .host_en     (host_en_q),
  .any_pending (any_grp)
);

// File: tb/serial_irq_aggregator_test.sv
module serial_irq_aggregator_test;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 4;
  localparam int NC = 8;
  localparam int NT = NG * NC;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NT-1:0] evt_rx_trig = '0, evt_tx_empty = '0, evt_special = '0;
  logic [NT-1:0] cd_in = '0, cts_in = '0, dsr_in = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]    reg_addr = '0, reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          host_irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_irq_aggregator #(.NUM_GROUPS(NG), .CHANS(NC), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst),
    .evt_rx_trig(evt_rx_trig), .evt_tx_empty(evt_tx_empty), .evt_special(evt_special),
    .cd_in(cd_in), .cts_in(cts_in), .dsr_in(dsr_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .host_irq(host_irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  // kind: 0 rx trigger, 1 tx empty, 2 special
  task automatic pulse(input int kind, input int idx);
    @(negedge clk);
    case (kind)
      0: evt_rx_trig[idx]  = 1'b1;
      1: evt_tx_empty[idx] = 1'b1;
      default: evt_special[idx] = 1'b1;
    endcase
    @(negedge clk);
    evt_rx_trig = '0; evt_tx_empty = '0; evt_special = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11 host_irq after reset", {7'b0, host_irq}, 8'h00);
    check("R11 rdata after reset", reg_rdata, 8'h00);
    rd(8'h80, rv); check("R11 status after reset", rv, 8'h00);
    rd(8'h81, rv); check("R11 control after reset", rv, 8'h00);
    rd(8'h2B, rv); check("R11 enable after reset", rv, 8'h00);
  endtask

  task automatic t_cause_bits();
    pulse(0, 1); pulse(1, 1); pulse(2, 1);       // group 0 channel 1
    rd(8'h01, rv); check("R1 cause bits 5,4,3", rv, 8'h38);
    rd(8'h01, rv); check("R1 cleared by read", rv, 8'h00);
    check("R10 rdata zero when idle", reg_rdata, 8'h00);
    // event in the same cycle as the read survives
    pulse(1, 1);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 8'h01; evt_special[1] = 1'b1;
    @(negedge clk); reg_rd = 1'b0; evt_special[1] = 1'b0; rv = reg_rdata;
    check("R1 read returns pre-read flags", rv, 8'h10);
    rd(8'h01, rv); check("R1 same-cycle event kept", rv, 8'h08);
  endtask

  task automatic t_modem();
    int idx = 1*NC + 2;                            // group 1 channel 2
    @(negedge clk); cd_in[idx] = 1'b1;
    idle(5);
    rd(8'h22, rv); check("R2 CD rising sets bit 2", rv, 8'h04);
    rd(8'h22, rv); check("R2 cleared by read", rv, 8'h00);
    @(negedge clk); cd_in[idx] = 1'b0; cts_in[idx] = 1'b1; dsr_in[idx] = 1'b1;
    idle(5);
    rd(8'h22, rv); check("R2 CD fall, CTS and DSR rise", rv, 8'h07);
  endtask

  task automatic t_enable_irq();
    int idx = 2*NC + 5;                            // group 2 channel 5
    wr(8'h4D, 8'hF1);
    rd(8'h4D, rv); check("R3 enable readback upper zero", rv, 8'h01);
    pulse(0, idx); pulse(2, idx);
    rd(8'h50, rv); check("R3 disabled causes give no interrupt", rv, 8'h00);
    rd(8'h80, rv); check("R6 status clear with no interrupt", rv, 8'h00);
    wr(8'h4D, 8'h04);
    rd(8'h50, rv); check("R5 group byte bit 5", rv, 8'h20);
    rd(8'h50, rv); check("R5 group byte not cleared by read", rv, 8'h20);
    rd(8'h80, rv); check("R6 status bit 2, high nibble zero", rv, 8'h04);
    rd(8'h45, rv); check("R1 cause of group 2 channel 5", rv, 8'h28);
    rd(8'h50, rv); check("R3 interrupt gone after clear", rv, 8'h00);
    wr(8'h4D, 8'h00);
  endtask

  task automatic t_rxtrig_ungated();
    int idx = 3*NC + 0;                            // group 3 channel 0
    wr(8'h68, 8'h0D);                              // all but rx enable
    pulse(0, idx);
    rd(8'h70, rv); check("R4 rx trigger no interrupt when disabled", rv, 8'h00);
    wr(8'h68, 8'h02);
    rd(8'h70, rv); check("R4 rx flag held, enable raises interrupt", rv, 8'h01);
    rd(8'h60, rv); check("R4 rx trigger flag set", rv, 8'h20);
    wr(8'h68, 8'h00);
  endtask

  task automatic t_host();
    int idx = 3*NC + 7;                            // group 3 channel 7
    wr(8'h6F, 8'h08);
    pulse(1, idx);
    idle(2);
    check("R7 no host_irq while disabled", {7'b0, host_irq}, 8'h00);
    wr(8'h81, 8'h08);
    check("R7 not yet one cycle", {7'b0, host_irq}, 8'h00);
    @(negedge clk);
    check("R7 host_irq raised", {7'b0, host_irq}, 8'h01);
    rd(8'h81, rv); check("R7 control readback", rv, 8'h08);
    wr(8'h81, 8'h0C);
    check("R8 end-of-interrupt clears", {7'b0, host_irq}, 8'h00);
    @(negedge clk);
    check("R8 re-asserts while pending", {7'b0, host_irq}, 8'h01);
    rd(8'h67, rv); check("R1 tx empty flag", rv, 8'h10);
    idle(2);
    check("R8 latched after cause cleared", {7'b0, host_irq}, 8'h01);
    wr(8'h81, 8'h0C);
    idle(3);
    check("R8 stays low with nothing pending", {7'b0, host_irq}, 8'h00);
    wr(8'h81, 8'h00);
    wr(8'h6F, 8'h00);
  endtask

  task automatic t_group_reset();
    wr(8'h08, 8'h0F);                              // group 0 channel 0 enable
    pulse(2, 0);
    pulse(2, 1*NC + 3);                            // group 1 channel 3
    wr(8'h11, 8'h80);
    pulse(0, 0);
    rd(8'h00, rv); check("R9 cause cleared in reset", rv, 8'h00);
    rd(8'h08, rv); check("R9 enable cleared in reset", rv, 8'h00);
    wr(8'h11, 8'h00);
    rd(8'h23, rv); check("R9 other group unaffected", rv, 8'h08);
    pulse(0, 0);
    rd(8'h00, rv); check("R9 events accepted after release", rv, 8'h20);
  endtask

  task automatic t_unmapped();
    rd(8'h11, rv); check("R10 command register reads zero", rv, 8'h00);
    rd(8'h1F, rv); check("R10 unmapped group offset", rv, 8'h00);
    rd(8'h85, rv); check("R10 unmapped controller offset", rv, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_cause_bits();
    t_modem();
    t_enable_irq();
    t_rxtrig_ungated();
    t_host();
    t_group_reset();
    t_unmapped();
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule